// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block is an eight-input priority interrupt controller core. It latches incoming requests in a request register. It filters them through a per-line mask that sits after that register. It tracks which interrupts are being serviced in an in-service register. A fixed priority picks the winner: line 0 is highest and line 7 is lowest. The controller raises `int_req` toward the processor only for an unmasked request that outranks everything currently in service.

The processor acknowledges with two one-cycle pulses on `ack_pulse`. A small state machine tracks the handshake with three states:

- `ST_IDLE` waits for a first pulse.
- `ST_GAP` sits between the pulses.
- `ST_VEC` is the single cycle in which the vector is presented.

The transitions are:

- `ST_IDLE` → `ST_GAP` on the first pulse (the "take1" transition).
- `ST_GAP` → `ST_VEC` on the second pulse (the "take2" transition).
- `ST_VEC` → `ST_IDLE` unconditionally on the following clock.

Pulses in `ST_VEC` are ignored.

The same block works as a master or as a slave, selected by `is_master`. A master may have any of its request lines marked as fed by a slave. For such a line, the master drives the line number onto the 3-bit cascade bus from the cycle after the first pulse until the vector cycle ends, and it does not present a vector itself. A slave commits its acknowledge only when the cascade value at the second pulse equals its `slave_id`. Up to eight slaves under one master give 64 request levels. The master may also use automatic end-of-interrupt, which drops the in-service bit at the second pulse.

Top module: `cascade_prio_intc`

## Requirements
- R1: After reset, the mask, request, in-service, slave-map and configuration registers read 0, `int_req` is 0, `vector_valid` is 0, `vector` is 0 and `cas_out` is 0.
- R2: A high level on `irq_in[i]` for one clock sets request bit i, and the bit stays set until that line is acknowledged, whatever the mask holds. Request bits read at `rd_sel`=4 and in-service bits at `rd_sel`=5, with bit i for line i.
- R3: Writing `wr_sel`=0 loads the mask, where bit i set masks line i. A masked pending line never raises `int_req`. Clearing its mask bit raises `int_req` on the clock after the write. The mask reads back at `rd_sel`=0.
- R4: Among eligible lines, the lowest index wins. The vector is {base, line}, with the 5-bit base in bits 7:3 and the line number in bits 2:0. The base is written with `wr_sel`=1 into data bits 4:0 and reads back at `rd_sel`=1.
- R5: A pending unmasked line raises `int_req` only if its index is lower than every in-service bit.
- R6: `int_req` is asserted only in `ST_IDLE`. The first pulse moves a master's winning line from the request register to the in-service register. `vector_valid` is high for exactly the one cycle after the second pulse, in `ST_VEC`.
- R7: With automatic end-of-interrupt enabled (config data bit 5) in a master, the in-service bit is cleared at the second pulse. A lower-priority request may then raise `int_req` at once.
- R8: In a slave, the automatic end-of-interrupt bit is ignored: it reads back 0 at `rd_sel`=1 and an acknowledged in-service bit stays set.
- R9: A write with `wr_sel`=3 (non-specific end-of-interrupt) clears only the highest-priority in-service bit. The data is ignored.
- R10: In a master, when the acknowledged line has its slave-map bit set (`wr_sel`=2, bit i for line i, read at `rd_sel`=2), `cas_out` carries the line number in `ST_GAP` and `ST_VEC`, and `vector_valid` stays 0.
- R11: `cas_out` is 0 in `ST_IDLE`, for lines without a slave, and always in slave mode.
- R12: A slave presents its vector and sets its in-service bit only if `cas_in` equals `slave_id` at the second pulse. Otherwise the vector is 0 and no register changes.
- R13: An acknowledge with no eligible line gives vector {base, 7} and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, line 0 highest |
| ack_pulse | input | 1 | Acknowledge pulse, one cycle each, two per handshake |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 config, 2 slave map, 3 end-of-interrupt |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read select: 0 mask, 1 config, 2 slave map, 4 request, 5 in-service |
| rd_data | output | 8 | Read data |
| is_master | input | 1 | 1 = master, 0 = slave |
| slave_id | input | 3 | Identity of this controller as a slave |
| cas_in | input | 3 | Cascade bus seen by a slave |
| int_req | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Interrupt vector, 0 when not valid |
| vector_valid | output | 1 | Vector present this cycle |
| cas_out | output | 3 | Cascade bus driven by a master |

## Verification
The assertions rely on the following properties of the inputs:

- `is_master` and `slave_id` change only under reset.
- Each acknowledge pulse lasts one cycle.
- No end-of-interrupt write shares a cycle with an acknowledge pulse.

The stimulus holds those inputs fixed between resets. It drives every pulse, write and request from single-cycle tasks. It drops each request line before the acknowledge that services it, so the set-wins rule of the request register never re-latches a serviced line.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_VEC  = 2'd2
    } ack_state_e;

    localparam logic [1:0] WSEL_MASK = 2'd0;
    localparam logic [1:0] WSEL_CFG  = 2'd1;
    localparam logic [1:0] WSEL_SMAP = 2'd2;
    localparam logic [1:0] WSEL_EOI  = 2'd3;

    localparam logic [2:0] RSEL_MASK = 3'd0;
    localparam logic [2:0] RSEL_CFG  = 3'd1;
    localparam logic [2:0] RSEL_SMAP = 3'd2;
    localparam logic [2:0] RSEL_IRR  = 3'd4;
    localparam logic [2:0] RSEL_ISR  = 3'd5;
endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // lowest set index wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_ack_fsm.sv
module intc_ack_fsm
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack,
    output ack_state_e state,
    output logic       take1,
    output logic       take2
);
    ack_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt   = state;
        take1 = 1'b0;
        take2 = 1'b0;
        unique case (state)
            ST_IDLE: if (ack) begin
                take1 = 1'b1;
                nxt   = ST_GAP;
            end
            ST_GAP: if (ack) begin
                take2 = 1'b1;
                nxt   = ST_VEC;
            end
            ST_VEC:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_VEC |=> state == ST_IDLE); // R6
endmodule

// File: rtl/cascade_prio_intc.sv
module cascade_prio_intc
    import intc_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES-1:0]         irq_in,
    input  logic                       ack_pulse,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [N_LINES-1:0]         wr_data,
    input  logic [2:0]                 rd_sel,
    output logic [N_LINES-1:0]         rd_data,
    input  logic                       is_master,
    input  logic [$clog2(N_LINES)-1:0] slave_id,
    input  logic [$clog2(N_LINES)-1:0] cas_in,
    output logic                       int_req,
    output logic [VEC_W-1:0]           vector,
    output logic                       vector_valid,
    output logic [$clog2(N_LINES)-1:0] cas_out
);
    localparam int IW     = $clog2(N_LINES);
    localparam int BASE_W = VEC_W - IW;

    logic [N_LINES-1:0] imr_q, irr_q, isr_q, smap_q;
    logic [BASE_W-1:0]  base_q;
    logic               aeoi_q;
    logic [IW-1:0]      cur_q;
    logic               spur_q, cassel_q, drive_ok_q;

    ack_state_e         state;
    logic               take1, take2;
    logic [N_LINES-1:0] above, eligible;
    logic               win_hit, isr_hit;
    logic [IW-1:0]      win_idx, isr_idx;
    logic [N_LINES-1:0] isr_set, isr_clr, irr_clr;
    logic               eoi_wr, id_match;

    intc_ack_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ack_pulse),
        .state (state),
        .take1 (take1),
        .take2 (take2)
    );

    intc_prio_pick #(.N(N_LINES), .IW(IW)) u_isr_pick (
        .req (isr_q),
        .hit (isr_hit),
        .idx (isr_idx)
    );

    // lines strictly above the top in-service level
    for (genvar g = 0; g < N_LINES; g++) begin : g_above
        assign above[g] = !isr_hit || (IW'(g) < isr_idx);
    end

    assign eligible = irr_q & ~imr_q & above;

    intc_prio_pick #(.N(N_LINES), .IW(IW)) u_win_pick (
        .req (eligible),
        .hit (win_hit),
        .idx (win_idx)
    );

    assign eoi_wr   = wr_en && (wr_sel == WSEL_EOI);
    assign id_match = (cas_in == slave_id);
    assign int_req  = win_hit && (state == ST_IDLE);

    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        irr_clr = '0;
        if (take1 && is_master && win_hit) begin
            isr_set[win_idx] = 1'b1;
            irr_clr[win_idx] = 1'b1;
        end
        if (take2 && !is_master && id_match && !spur_q) begin
            isr_set[cur_q] = 1'b1;
            irr_clr[cur_q] = 1'b1;
        end
        if (take2 && is_master && aeoi_q && !spur_q)
            isr_clr[cur_q] = 1'b1;
        if (eoi_wr && isr_hit)
            isr_clr[isr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q      <= '0;
            irr_q      <= '0;
            isr_q      <= '0;
            smap_q     <= '0;
            base_q     <= '0;
            aeoi_q     <= 1'b0;
            cur_q      <= '0;
            spur_q     <= 1'b0;
            cassel_q   <= 1'b0;
            drive_ok_q <= 1'b0;
        end else begin
            irr_q <= (irr_q & ~irr_clr) | irq_in;
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (wr_en) begin
                unique case (wr_sel)
                    WSEL_MASK: imr_q <= wr_data;
                    WSEL_CFG: begin
                        base_q <= wr_data[BASE_W-1:0];
                        aeoi_q <= wr_data[BASE_W] & is_master;
                    end
                    WSEL_SMAP: smap_q <= wr_data;
                    default: ;
                endcase
            end
            if (take1) begin
                cur_q    <= win_hit ? win_idx : IW'(N_LINES - 1);
                spur_q   <= !win_hit;
                cassel_q <= is_master && win_hit && smap_q[win_idx];
            end
            if (take2)
                drive_ok_q <= is_master ? !cassel_q : id_match;
        end
    end

    // outputs
    always_comb begin
        vector_valid = (state == ST_VEC) && drive_ok_q;
        vector       = vector_valid ? {base_q, cur_q} : '0;
        cas_out      = ((state != ST_IDLE) && cassel_q) ? cur_q : '0;
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            RSEL_MASK: rd_data = imr_q;
            RSEL_CFG:  rd_data = N_LINES'({aeoi_q, base_q});
            RSEL_SMAP: rd_data = smap_q;
            RSEL_IRR:  rd_data = irr_q;
            RSEL_ISR:  rd_data = isr_q;
            default:   rd_data = '0;
        endcase
    end

    AST_INTREQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> |(irr_q & ~imr_q)); // R3
    AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && isr_hit) |-> (win_idx < isr_idx)); // R5
    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |-> $past(ack_pulse)); // R6
    AST_SLAVE_NO_AEOI: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !aeoi_q); // R8
    AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_pulse && (isr_q != '0)) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9
    AST_CAS_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && (cas_out != '0)) |-> !vector_valid); // R10
    AST_CAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (cas_out == '0)); // R11
endmodule

// File: tb/sim_cascade_prio_intc.sv
module sim_cascade_prio_intc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       ack_pulse = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       is_master = 1'b1;
    logic [2:0] slave_id = '0;
    logic [2:0] cas_in = '0;
    logic       int_req, vector_valid;
    logic [7:0] vector;
    logic [2:0] cas_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cascade_prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_pulse(ack_pulse),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .is_master(is_master), .slave_id(slave_id),
        .cas_in(cas_in), .int_req(int_req), .vector(vector),
        .vector_valid(vector_valid), .cas_out(cas_out)
    );

    // behavioural reference model
    bit [7:0] m_irr, m_imr, m_isr, m_smap;
    int m_base, m_st, m_cur;
    bit m_aeoi, m_spur, m_cas, m_ok;

    function automatic int top_isr(bit [7:0] s);
        for (int i = 0; i < 8; i++) if (s[i]) return i;
        return -1;
    endfunction

    function automatic int winner(bit [7:0] r, bit [7:0] m, bit [7:0] s);
        int h = top_isr(s);
        if (h < 0) h = 8;
        for (int i = 0; i < h; i++) if (r[i] && !m[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int w, h;
        bit [7:0] nirr, nisr;
        if (!rst_n) begin
            m_irr = 0; m_imr = 0; m_isr = 0; m_smap = 0; m_base = 0;
            m_aeoi = 0; m_st = 0; m_cur = 0; m_spur = 0; m_cas = 0; m_ok = 0;
        end else begin
            w = winner(m_irr, m_imr, m_isr);
            h = top_isr(m_isr);
            nirr = m_irr; nisr = m_isr;
            if (wr_en && wr_sel == 3 && h >= 0) nisr[h] = 0;
            if (m_st == 0 && ack_pulse) begin
                if (is_master && w >= 0) begin nisr[w] = 1; nirr[w] = 0; end
                m_cur = (w >= 0) ? w : 7;
                m_spur = (w < 0);
                m_cas = is_master && (w >= 0) && m_smap[(w >= 0) ? w : 0];
                m_st = 1;
            end else if (m_st == 1 && ack_pulse) begin
                if (is_master) begin
                    m_ok = !m_cas;
                    if (m_aeoi && !m_spur) nisr[m_cur] = 0;
                end else begin
                    m_ok = (cas_in == slave_id);
                    if (m_ok && !m_spur) begin nisr[m_cur] = 1; nirr[m_cur] = 0; end
                end
                m_st = 2;
            end else if (m_st == 2) m_st = 0;
            if (wr_en) begin
                if (wr_sel == 0) m_imr = wr_data;
                if (wr_sel == 1) begin m_base = wr_data[4:0]; m_aeoi = wr_data[5] && is_master; end
                if (wr_sel == 2) m_smap = wr_data;
            end
            m_irr = nirr | irq_in;
            m_isr = nisr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(posedge clk) begin
        int ev, ec;
        bit evv, eir;
        #3;
        if (rst_n && !done) begin
            evv = (m_st == 2) && m_ok;
            ev = evv ? (m_base * 8 + m_cur) : 0;
            ec = (m_st != 0 && m_cas) ? m_cur : 0;
            eir = (m_st == 0) && (winner(m_irr, m_imr, m_isr) >= 0);
            chk("R6 cycle int_req", int'(int_req), int'(eir));
            chk("R4 cycle vector_valid", int'(vector_valid), int'(evv));
            chk("R4 cycle vector", int'(vector), ev);
            chk("R10 cycle cas_out", int'(cas_out), ec);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] s, output int v);
        rd_sel = s;
        #1;
        v = int'(rd_data);
    endtask

    task automatic req(input logic [7:0] m);
        irq_in = m;
        tick();
        irq_in = 0;
    endtask

    task automatic pulse();
        ack_pulse = 1;
        tick();
        ack_pulse = 0;
    endtask

    task automatic do_reset(input logic master, input logic [2:0] id);
        rst_n = 0; is_master = master; slave_id = id;
        repeat (2) tick();
        rst_n = 1;
        tick();
    endtask

    initial begin
        int v;
        @(negedge clk);
        do_reset(1'b1, 3'd0);
        // R1 reset state
        rd(0, v); chk("R1 mask", v, 0);
        rd(1, v); chk("R1 config", v, 0);
        rd(2, v); chk("R1 slave map", v, 0);
        rd(4, v); chk("R1 request", v, 0);
        rd(5, v); chk("R1 in-service", v, 0);
        chk("R1 int_req", int'(int_req), 0);
        chk("R1 cas_out", int'(cas_out), 0);
        chk("R1 vector", int'(vector), 0);

        wr(1, 8'h12);
        rd(1, v); chk("R4 base readback", v, 8'h12);
        // R2 / R3 masked request latches
        wr(0, 8'h08);
        rd(0, v); chk("R3 mask readback", v, 8'h08);
        req(8'h08);
        rd(4, v); chk("R2 masked line latched", v, 8'h08);
        chk("R3 masked no int_req", int'(int_req), 0);
        tick();
        rd(4, v); chk("R2 request held", v, 8'h08);
        wr(0, 8'h00);
        chk("R3 unmask raises int_req", int'(int_req), 1);
        // R6 acknowledge
        pulse();
        rd(5, v); chk("R6 in-service after first pulse", v, 8'h08);
        rd(4, v); chk("R6 request cleared", v, 0);
        chk("R6 int_req low in gap", int'(int_req), 0);
        pulse();
        chk("R6 vector_valid", int'(vector_valid), 1);
        chk("R4 vector line 3", int'(vector), 8'h93);
        tick();
        chk("R6 vector_valid one cycle", int'(vector_valid), 0);
        // R5 nesting
        req(8'h20);
        chk("R5 lower level blocked", int'(int_req), 0);
        req(8'h02);
        chk("R5 higher level raises", int'(int_req), 1);
        pulse(); pulse();
        chk("R5 nested vector", int'(vector), 8'h91);
        tick();
        rd(5, v); chk("R5 two in service", v, 8'h0A);
        wr(3, 8'hFF);
        rd(5, v); chk("R9 eoi clears top bit only", v, 8'h08);
        chk("R5 still blocked", int'(int_req), 0);
        wr(3, 8'h00);
        rd(5, v); chk("R9 second eoi", v, 0);
        chk("R5 released", int'(int_req), 1);
        pulse(); pulse();
        chk("R4 vector line 5", int'(vector), 8'h95);
        tick(); wr(3, 0);
        // R4 priority between simultaneous lines
        req(8'h44);
        pulse(); pulse();
        chk("R4 line 2 before 6", int'(vector), 8'h92);
        tick(); wr(3, 0);
        pulse(); pulse();
        chk("R4 line 6 next", int'(vector), 8'h96);
        tick(); wr(3, 0);
        // R7 automatic end-of-interrupt
        wr(1, 8'h32);
        rd(1, v); chk("R7 aeoi readback", v, 8'h32);
        req(8'h10);
        pulse();
        rd(5, v); chk("R7 set at first pulse", v, 8'h10);
        pulse();
        rd(5, v); chk("R7 cleared at second pulse", v, 0);
        chk("R7 vector line 4", int'(vector), 8'h94);
        tick();
        req(8'h40);
        chk("R7 lower priority interrupts", int'(int_req), 1);
        pulse(); pulse(); tick();
        rd(5, v); chk("R7 still empty", v, 0);
        wr(1, 8'h12);
        // R10 / R11 cascade
        wr(2, 8'h04);
        rd(2, v); chk("R10 slave map readback", v, 8'h04);
        req(8'h04);
        chk("R11 idle cascade low", int'(cas_out), 0);
        pulse();
        chk("R10 cascade in gap", int'(cas_out), 2);
        pulse();
        chk("R10 cascade in vector cycle", int'(cas_out), 2);
        chk("R10 master silent", int'(vector_valid), 0);
        tick();
        chk("R11 cascade back low", int'(cas_out), 0);
        wr(3, 0);
        // R13 spurious
        pulse(); pulse();
        chk("R13 spurious vector", int'(vector), 8'h97);
        tick();
        rd(5, v); chk("R13 in-service untouched", v, 0);

        // slave mode
        do_reset(1'b0, 3'd5);
        wr(1, 8'h3F);
        rd(1, v); chk("R8 slave ignores aeoi", v, 8'h1F);
        req(8'h01);
        cas_in = 3'd3;
        pulse(); pulse();
        chk("R12 other id no vector", int'(vector_valid), 0);
        chk("R11 slave cascade low", int'(cas_out), 0);
        tick();
        rd(4, v); chk("R12 request kept", v, 8'h01);
        rd(5, v); chk("R12 in-service kept", v, 0);
        cas_in = 3'd5;
        pulse(); pulse();
        chk("R12 match vector", int'(vector), 8'hF8);
        tick();
        rd(5, v); chk("R8 slave in-service held", v, 8'h01);
        rd(4, v); chk("R12 request cleared", v, 0);
        repeat (3) tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule